// File: doc/BRIEF.md
# Burst DMA Engine

This block moves bulk data for a single hardware thread between a dual-ported local scratchpad and the DRAM partition that belongs to that thread alone. Software hands it a descriptor: a direction flag, a scratchpad base, a DRAM base and a byte count. The engine cuts the transfer into whole bursts and posts them one at a time into the backend's single-place request buffer. It offers a request whenever the buffer signals that it is free. For scratchpad-to-DRAM moves it fetches each burst from the scratchpad and attaches it to the request. For DRAM-to-scratchpad moves it writes each returned burst into consecutive scratchpad bursts.

While a transfer runs, the engine owns the thread's DRAM access, so any direct DRAM access by the thread is held off. A thread access to the scratchpad is held off only when it falls inside the burst range being moved; the thread keeps using the rest of the scratchpad in the same cycles, through its own port. An activity level tells the refresh logic when a transfer starts and ends. A one-cycle done pulse marks completion.

Top module: `burst_dma_engine`

## Requirements
- R1: After reset, and whenever no transfer is active, the engine is ready for a descriptor and does not assert done, the activity level, a request, a scratchpad read or a scratchpad write.
- R2: A byte count of N produces exactly ceil(N / B) accepted requests, where B is the burst size (BURST_LEN x BUS_BYTES, 32 bytes by default). A count of zero produces no request, and done pulses in the cycle after the descriptor is taken.
- R3: The k-th request (counted from 0) carries DRAM address dram_base + k*B. Its write flag is 1 for a scratchpad-to-DRAM move (descriptor direction bit = 1) and 0 for a DRAM-to-scratchpad move.
- R4: While a request is offered and the buffer is not free, the request stays offered with its address and data unchanged. A request counts as accepted only in a cycle where both valid and ready are high.
- R5: In a scratchpad-to-DRAM move, the data of the k-th request equals the scratchpad burst at sp_base + k*B. The scratchpad returns read data one cycle after the read strobe.
- R6: In a DRAM-to-scratchpad move, the k-th returned burst is written to scratchpad address sp_base + k*B in the cycle it arrives. A returned burst presented while no read transfer is active causes no scratchpad write.
- R7: Done is a single-cycle pulse. It occurs in the cycle after the last returned burst is written (read move) or after the last request is accepted (write move). The activity level is low in that cycle.
- R8: The activity level rises in the cycle after a descriptor with a nonzero count is taken and stays high until the done cycle. Ready for a descriptor is low exactly while the level is high.
- R9: While the engine is active, a direct DRAM access by the thread is stalled. While it is idle, no such stall is raised.
- R10: A thread scratchpad access is stalled only while active and only if its address lies in [sp_base, sp_base + ceil(N/B)*B). Other addresses are not stalled.
- R11: A descriptor presented while a transfer is active is ignored. The running transfer continues with its original addresses and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Engine idle, descriptor taken when valid |
| desc_to_dram_i | input | 1 | 1: scratchpad to DRAM, 0: DRAM to scratchpad |
| desc_sp_base_i | input | SP_AW | Scratchpad byte base (burst aligned) |
| desc_dram_base_i | input | DR_AW | DRAM byte base (burst aligned) |
| desc_bytes_i | input | LEN_W | Byte count |
| done_o | output | 1 | Completion pulse |
| xfer_active_o | output | 1 | Transfer in progress, for refresh scheduling |
| req_valid_o | output | 1 | Request offered to backend buffer |
| req_ready_i | input | 1 | Backend request buffer free |
| req_write_o | output | 1 | Request is a write |
| req_addr_o | output | DR_AW | Request DRAM byte address |
| req_wdata_o | output | BURST_LEN*BUS_BYTES*8 | Write burst data |
| rsp_valid_i | input | 1 | Read burst returned |
| rsp_rdata_i | input | BURST_LEN*BUS_BYTES*8 | Returned burst data |
| sp_re_o | output | 1 | Scratchpad read strobe (engine port) |
| sp_we_o | output | 1 | Scratchpad write strobe (engine port) |
| sp_addr_o | output | SP_AW | Scratchpad byte address (engine port) |
| sp_wdata_o | output | BURST_LEN*BUS_BYTES*8 | Scratchpad write data |
| sp_rdata_i | input | BURST_LEN*BUS_BYTES*8 | Scratchpad read data, one cycle after strobe |
| thr_dram_req_i | input | 1 | Thread attempts a direct DRAM access |
| thr_dram_stall_o | output | 1 | Thread DRAM access held off |
| thr_sp_req_i | input | 1 | Thread scratchpad access |
| thr_sp_addr_i | input | SP_AW | Thread scratchpad byte address |
| thr_sp_stall_o | output | 1 | Thread scratchpad access held off |

## Verification
The checks assume that the backend returns bursts only for read requests it has accepted, in order and at most one per cycle, and that descriptor bases are burst aligned and do not wrap the scratchpad. The bench keeps to this. Its backend model opens one request slot per 13-cycle period and returns each read a fixed 9 cycles after acceptance. Its scratchpad model answers reads one cycle after the strobe. All bases in the stimulus are multiples of 32. Stray returned bursts are injected only while the engine is idle, which exercises the ignore rule without breaking the in-order assumption.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } eng_state_e;

    typedef enum logic {
        DIR_TO_SP   = 1'b0,
        DIR_TO_DRAM = 1'b1
    } dir_e;
endpackage

// File: rtl/dma_burst_split.sv
// Converts a byte count into a number of whole bursts, rounding up.
module dma_burst_split #(
    parameter int LEN_W       = 16,
    parameter int BURST_BYTES = 32,
    localparam int BSH        = $clog2(BURST_BYTES),
    localparam int CNT_W      = LEN_W - BSH + 1
) (
    input  logic [LEN_W-1:0] bytes_i,
    output logic [CNT_W-1:0] nreq_o
);
    localparam logic [LEN_W:0] ROUND = (LEN_W+1)'(BURST_BYTES - 1);

    logic [LEN_W:0] sum;

    always_comb begin
        sum    = {1'b0, bytes_i} + ROUND;
        nreq_o = sum[LEN_W:BSH];
    end
endmodule

// File: rtl/dma_range_guard.sv
// Flags a thread scratchpad address that falls inside the active burst range.
module dma_range_guard #(
    parameter int AW    = 16,
    parameter int CW    = 12,
    parameter int BSH   = 5
) (
    input  logic          en_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] nreq_i,
    input  logic [AW-1:0] addr_i,
    output logic          hit_o
);
    logic [AW:0] lo;
    logic [AW:0] hi;
    logic [AW:0] span;
    logic [AW:0] probe;

    always_comb begin
        span  = (AW+1)'(nreq_i) << BSH;
        lo    = {1'b0, base_i};
        hi    = lo + span;
        probe = {1'b0, addr_i};
        hit_o = en_i && (probe >= lo) && (probe < hi);
    end
endmodule

// File: rtl/burst_dma_engine.sv
module burst_dma_engine
    import dma_pkg::*;
#(
    parameter int SP_AW     = 16,
    parameter int DR_AW     = 32,
    parameter int LEN_W     = 16,
    parameter int BURST_LEN = 4,
    parameter int BUS_BYTES = 8
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                desc_valid_i,
    output logic                                desc_ready_o,
    input  logic                                desc_to_dram_i,
    input  logic [SP_AW-1:0]                    desc_sp_base_i,
    input  logic [DR_AW-1:0]                    desc_dram_base_i,
    input  logic [LEN_W-1:0]                    desc_bytes_i,
    output logic                                done_o,
    output logic                                xfer_active_o,
    output logic                                req_valid_o,
    input  logic                                req_ready_i,
    output logic                                req_write_o,
    output logic [DR_AW-1:0]                    req_addr_o,
    output logic [BURST_LEN*BUS_BYTES*8-1:0]    req_wdata_o,
    input  logic                                rsp_valid_i,
    input  logic [BURST_LEN*BUS_BYTES*8-1:0]    rsp_rdata_i,
    output logic                                sp_re_o,
    output logic                                sp_we_o,
    output logic [SP_AW-1:0]                    sp_addr_o,
    output logic [BURST_LEN*BUS_BYTES*8-1:0]    sp_wdata_o,
    input  logic [BURST_LEN*BUS_BYTES*8-1:0]    sp_rdata_i,
    input  logic                                thr_dram_req_i,
    output logic                                thr_dram_stall_o,
    input  logic                                thr_sp_req_i,
    input  logic [SP_AW-1:0]                    thr_sp_addr_i,
    output logic                                thr_sp_stall_o
);
    localparam int BURST_BYTES = BURST_LEN * BUS_BYTES;
    localparam int DW          = BURST_BYTES * 8;
    localparam int BSH         = $clog2(BURST_BYTES);
    localparam int CNT_W       = LEN_W - BSH + 1;

    localparam logic [SP_AW-1:0] SP_STEP = SP_AW'(BURST_BYTES);
    localparam logic [DR_AW-1:0] DR_STEP = DR_AW'(BURST_BYTES);
    localparam logic [SP_AW-1:0] SP_MASK = ~SP_AW'(BURST_BYTES - 1);
    localparam logic [DR_AW-1:0] DR_MASK = ~DR_AW'(BURST_BYTES - 1);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    typedef struct packed {
        eng_state_e       state;
        dir_e             dir;
        logic [SP_AW-1:0] sp_base;
        logic [SP_AW-1:0] sp_ptr;
        logic [DR_AW-1:0] dr_ptr;
        logic [CNT_W-1:0] nreq;
        logic [CNT_W-1:0] fetched;
        logic [CNT_W-1:0] issued;
        logic [CNT_W-1:0] recv;
        logic             pend;
        logic             stage_vld;
        logic [DW-1:0]    stage;
        logic             done;
    } regs_t;

    regs_t q, d;

    logic [CNT_W-1:0] nreq_w;
    logic             active;
    logic             accept;

    dma_burst_split #(
        .LEN_W       (LEN_W),
        .BURST_BYTES (BURST_BYTES)
    ) split_i (
        .bytes_i (desc_bytes_i),
        .nreq_o  (nreq_w)
    );

    dma_range_guard #(
        .AW  (SP_AW),
        .CW  (CNT_W),
        .BSH (BSH)
    ) guard_i (
        .en_i   (active && thr_sp_req_i),
        .base_i (q.sp_base),
        .nreq_i (q.nreq),
        .addr_i (thr_sp_addr_i),
        .hit_o  (thr_sp_stall_o)
    );

    assign active = (q.state == ST_RUN);

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        sp_re_o     = 1'b0;
        sp_we_o     = 1'b0;
        req_valid_o = 1'b0;
        accept      = 1'b0;

        case (q.state)
            ST_IDLE: begin
                if (desc_valid_i) begin
                    d.dir       = desc_to_dram_i ? DIR_TO_DRAM : DIR_TO_SP;
                    d.sp_base   = desc_sp_base_i & SP_MASK;
                    d.sp_ptr    = desc_sp_base_i & SP_MASK;
                    d.dr_ptr    = desc_dram_base_i & DR_MASK;
                    d.nreq      = nreq_w;
                    d.fetched   = '0;
                    d.issued    = '0;
                    d.recv      = '0;
                    d.pend      = 1'b0;
                    d.stage_vld = 1'b0;
                    if (nreq_w == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.state = ST_RUN;
                    end
                end
            end

            ST_RUN: begin
                if (q.dir == DIR_TO_DRAM) begin
                    // scratchpad data arrives one cycle after the strobe
                    if (q.pend) begin
                        d.stage     = sp_rdata_i;
                        d.stage_vld = 1'b1;
                        d.pend      = 1'b0;
                    end
                    if (!q.stage_vld && !q.pend && (q.fetched != q.nreq)) begin
                        sp_re_o   = 1'b1;
                        d.pend    = 1'b1;
                        d.fetched = q.fetched + ONE;
                        d.sp_ptr  = q.sp_ptr + SP_STEP;
                    end
                    req_valid_o = q.stage_vld;
                    accept      = q.stage_vld && req_ready_i;
                    if (accept) begin
                        d.stage_vld = 1'b0;
                        d.dr_ptr    = q.dr_ptr + DR_STEP;
                        d.issued    = q.issued + ONE;
                        if (q.issued + ONE == q.nreq) begin
                            d.state = ST_IDLE;
                            d.done  = 1'b1;
                        end
                    end
                end else begin
                    req_valid_o = (q.issued != q.nreq);
                    accept      = req_valid_o && req_ready_i;
                    if (accept) begin
                        d.dr_ptr = q.dr_ptr + DR_STEP;
                        d.issued = q.issued + ONE;
                    end
                    if (rsp_valid_i) begin
                        sp_we_o  = 1'b1;
                        d.sp_ptr = q.sp_ptr + SP_STEP;
                        d.recv   = q.recv + ONE;
                        if (q.recv + ONE == q.nreq) begin
                            d.state = ST_IDLE;
                            d.done  = 1'b1;
                        end
                    end
                end
            end

            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign desc_ready_o     = (q.state == ST_IDLE);
    assign xfer_active_o    = active;
    assign done_o           = q.done;
    assign req_write_o      = (q.dir == DIR_TO_DRAM);
    assign req_addr_o       = q.dr_ptr;
    assign req_wdata_o      = q.stage;
    assign sp_addr_o        = q.sp_ptr;
    assign sp_wdata_o       = rsp_rdata_i;
    assign thr_dram_stall_o = active && thr_dram_req_i;
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
    parameter int DR_AW = 32,
    parameter int DW    = 256
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             desc_ready_o,
    input logic             done_o,
    input logic             xfer_active_o,
    input logic             req_valid_o,
    input logic             req_ready_i,
    input logic [DR_AW-1:0] req_addr_o,
    input logic [DW-1:0]    req_wdata_o,
    input logic             sp_we_o,
    input logic             thr_dram_req_i,
    input logic             thr_dram_stall_o,
    input logic             thr_sp_req_i,
    input logic             thr_sp_stall_o
);
    // R4
    offer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_wdata_o));

    // R7
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7
    done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !xfer_active_o);

    // R8
    busy_no_desc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer_active_o |-> !desc_ready_o);

    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !xfer_active_o |-> !req_valid_o);

    // R6
    idle_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !xfer_active_o |-> !sp_we_o);

    // R9
    dram_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer_active_o && thr_dram_req_i |-> thr_dram_stall_o);

    // R9
    dram_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !xfer_active_o |-> !thr_dram_stall_o);

    // R10
    sp_hold_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        thr_sp_stall_o |-> thr_sp_req_i && xfer_active_o);
endmodule

bind burst_dma_engine dma_engine_chk #(
    .DR_AW (DR_AW),
    .DW    (DW)
) chk_i (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .desc_ready_o     (desc_ready_o),
    .done_o           (done_o),
    .xfer_active_o    (xfer_active_o),
    .req_valid_o      (req_valid_o),
    .req_ready_i      (req_ready_i),
    .req_addr_o       (req_addr_o),
    .req_wdata_o      (req_wdata_o),
    .sp_we_o          (sp_we_o),
    .thr_dram_req_i   (thr_dram_req_i),
    .thr_dram_stall_o (thr_dram_stall_o),
    .thr_sp_req_i     (thr_sp_req_i),
    .thr_sp_stall_o   (thr_sp_stall_o)
);

// File: tb/burst_dma_engine_tb_top.sv
`timescale 1ns/1ps
module burst_dma_engine_tb_top;
    localparam int BB   = 32;
    localparam int PER  = 13;
    localparam int RLAT = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic         desc_valid = 1'b0;
    logic         desc_ready;
    logic         desc_to_dram = 1'b0;
    logic [15:0]  desc_sp_base = '0;
    logic [31:0]  desc_dram_base = '0;
    logic [15:0]  desc_bytes = '0;
    logic         done, active;
    logic         req_valid, req_ready, req_write;
    logic [31:0]  req_addr;
    logic [255:0] req_wdata;
    logic         rsp_valid;
    logic [255:0] rsp_rdata;
    logic         sp_re, sp_we;
    logic [15:0]  sp_addr;
    logic [255:0] sp_wdata;
    logic [255:0] sp_rdata;
    logic         thr_dram_req, thr_dram_stall;
    logic         thr_sp_req, thr_sp_stall;
    logic [15:0]  thr_sp_addr;

    burst_dma_engine dut_i (
        .clk_i (clk), .rst_ni (rst_n),
        .desc_valid_i (desc_valid), .desc_ready_o (desc_ready),
        .desc_to_dram_i (desc_to_dram), .desc_sp_base_i (desc_sp_base),
        .desc_dram_base_i (desc_dram_base), .desc_bytes_i (desc_bytes),
        .done_o (done), .xfer_active_o (active),
        .req_valid_o (req_valid), .req_ready_i (req_ready), .req_write_o (req_write),
        .req_addr_o (req_addr), .req_wdata_o (req_wdata),
        .rsp_valid_i (rsp_valid), .rsp_rdata_i (rsp_rdata),
        .sp_re_o (sp_re), .sp_we_o (sp_we), .sp_addr_o (sp_addr),
        .sp_wdata_o (sp_wdata), .sp_rdata_i (sp_rdata),
        .thr_dram_req_i (thr_dram_req), .thr_dram_stall_o (thr_dram_stall),
        .thr_sp_req_i (thr_sp_req), .thr_sp_addr_i (thr_sp_addr),
        .thr_sp_stall_o (thr_sp_stall)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [255:0] dram_pat(input int addr);
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = 32'(addr) ^ (32'h5A000000 + 32'(i * 7));
        return v;
    endfunction

    function automatic logic [255:0] sp_pat(input int idx);
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = 32'hC0DE0000 + 32'(idx * 16 + i);
        return v;
    endfunction

    // scratchpad model: 64 bursts, read data one cycle after strobe
    logic [255:0] sp_mem [64];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) sp_mem[i] <= sp_pat(i);
            sp_rdata <= '0;
        end else begin
            if (sp_we) sp_mem[sp_addr[10:5]] <= sp_wdata;
            if (sp_re) sp_rdata <= sp_mem[sp_addr[10:5]];
        end
    end

    // reference model state
    int  cyc = 0;
    int  bk_cnt = 0;
    int  rsp_due[$];
    logic [255:0] rsp_dat[$];
    bit  busy = 0;
    int  m_start = -1;
    int  m_end = -1;
    bit  m_dir = 0;
    int  m_sp = 0;
    int  m_dram = 0;
    int  m_n = 0;
    int  k_req = 0;
    int  k_rsp = 0;
    bit  fin_flag = 0;
    bit  spur_en = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            req_ready    = 1'b0;
            rsp_valid    = 1'b0;
            rsp_rdata    = '0;
            thr_dram_req = 1'b0;
            thr_sp_req   = 1'b0;
            thr_sp_addr  = '0;
        end else begin
            cyc++;
            req_ready = (bk_cnt == 0);
            bk_cnt    = (bk_cnt == PER - 1) ? 0 : bk_cnt + 1;
            rsp_valid = 1'b0;
            rsp_rdata = '0;
            if (rsp_due.size() > 0 && rsp_due[0] <= cyc) begin
                rsp_valid = 1'b1;
                rsp_rdata = rsp_dat[0];
                void'(rsp_due.pop_front());
                void'(rsp_dat.pop_front());
            end else if (spur_en) begin
                rsp_valid = 1'b1;
                rsp_rdata = {8{32'hDEADBEEF}};
            end
            thr_dram_req = (cyc % 3) != 0;
            thr_sp_req   = (cyc % 2) == 0;
            thr_sp_addr  = 16'(32'h0C0 + (cyc * 24) % 32'h200);
            #1;
            if (m_start == cyc) busy = 1;
            // R7: done pulse timing, R8: activity level and readiness
            if (m_end == cyc) begin
                busy = 0;
                fin_flag = 1;
                chk(done == 1'b1, "R7 done at completion", done, 1);
            end else begin
                chk(done == 1'b0, "R7 done only once", done, 0);
            end
            chk(active == busy, "R8 activity level", active, busy);
            chk(desc_ready == !busy, "R8 descriptor ready", desc_ready, !busy);
            // R1: idle outputs quiet
            if (!busy) chk(!req_valid && !sp_re && !sp_we, "R1 idle quiet",
                           {req_valid, sp_re, sp_we}, 0);
            // R9: DRAM interlock
            chk(thr_dram_stall == (busy && thr_dram_req), "R9 dram stall",
                thr_dram_stall, busy && thr_dram_req);
            // R10: scratchpad range interlock
            begin
                bit exp_s;
                exp_s = busy && thr_sp_req && (int'(thr_sp_addr) >= m_sp)
                        && (int'(thr_sp_addr) < m_sp + m_n * BB);
                chk(thr_sp_stall == exp_s, "R10 scratchpad stall", thr_sp_stall, exp_s);
            end
            if (req_valid && req_ready) begin
                int ea;
                ea = m_dram + k_req * BB;
                chk(busy && k_req < m_n, "R2 request count", k_req, m_n);
                chk(req_addr == 32'(ea), "R3 request address", req_addr, ea);
                chk(req_write == m_dir, "R3 write flag", req_write, m_dir);
                if (m_dir) begin
                    chk(req_wdata == sp_mem[(m_sp / BB + k_req) % 64], "R5 write data",
                        req_wdata, sp_mem[(m_sp / BB + k_req) % 64]);
                end else begin
                    rsp_due.push_back(cyc + RLAT);
                    rsp_dat.push_back(dram_pat(ea));
                end
                k_req++;
                if (m_dir && k_req == m_n) m_end = cyc + 1;
            end
            if (sp_we) begin
                chk(busy && !m_dir, "R6 write only in read move", sp_we, 0);
                chk(sp_addr == 16'(m_sp + k_rsp * BB), "R6 scratchpad address",
                    sp_addr, m_sp + k_rsp * BB);
                chk(sp_wdata == dram_pat(m_dram + k_rsp * BB), "R6 scratchpad data",
                    sp_wdata, dram_pat(m_dram + k_rsp * BB));
                k_rsp++;
                if (k_rsp == m_n) m_end = cyc + 1;
            end
            if (desc_valid && desc_ready) begin
                m_dir  = desc_to_dram;
                m_sp   = int'(desc_sp_base);
                m_dram = int'(desc_dram_base);
                m_n    = (int'(desc_bytes) + BB - 1) / BB;
                k_req  = 0;
                k_rsp  = 0;
                if (m_n == 0) m_end = cyc + 1;
                else m_start = cyc + 1;
            end
        end
    end

    task automatic run_xfer(input bit dir, input int sp, input int dram, input int bytes, input bit poke);
        fin_flag = 0;
        @(negedge clk);
        desc_valid     = 1'b1;
        desc_to_dram   = dir;
        desc_sp_base   = 16'(sp);
        desc_dram_base = 32'(dram);
        desc_bytes     = 16'(bytes);
        @(negedge clk);
        desc_valid = 1'b0;
        if (poke) begin
            // R11: a second descriptor while busy must be ignored
            repeat (3) @(negedge clk);
            desc_valid     = 1'b1;
            desc_to_dram   = !dir;
            desc_sp_base   = 16'h0400;
            desc_dram_base = 32'h0009_0000;
            desc_bytes     = 16'd64;
            repeat (6) @(negedge clk);
            desc_valid = 1'b0;
        end
        wait (fin_flag);
        chk(k_req == m_n, "R2 total requests", k_req, m_n);
        chk(m_n == (bytes + BB - 1) / BB, "R11 count kept", m_n, (bytes + BB - 1) / BB);
        if (!dir) chk(k_rsp == m_n, "R6 total bursts written", k_rsp, m_n);
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        chk(desc_ready == 1'b1, "R1 ready after reset", desc_ready, 1);
        chk(done == 1'b0 && active == 1'b0, "R1 no done or activity", {done, active}, 0);
        chk(req_valid == 1'b0, "R1 no request", req_valid, 0);
        run_xfer(1'b0, 32'h100, 32'h4000, 128, 1'b0);   // R6 read, 4 bursts
        run_xfer(1'b1, 32'h100, 32'h8000, 70, 1'b0);    // R2 rounding up, R5
        run_xfer(1'b0, 32'h000, 32'h2000, 0, 1'b0);     // R2 zero count
        run_xfer(1'b0, 32'h1E0, 32'h6020, 1, 1'b0);     // R2 single byte
        run_xfer(1'b1, 32'h040, 32'hA000, 96, 1'b1);    // R11 descriptor while busy
        run_xfer(1'b0, 32'h200, 32'hC000, 64, 1'b1);    // R11 in read direction
        // R6: stray returned bursts while idle
        @(negedge clk);
        spur_en = 1'b1;
        repeat (10) @(negedge clk);
        spur_en = 1'b0;
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule